// File: doc/BRIEF.md
# Data-Space Decoder with 8-Bit GPIO Port

This block sits between a small processor's data bus and the outside world. Each bus access carries an 8-bit address, write data, a write strobe and a read strobe. The decoder sorts every address into one of three regions: the data RAM, the I/O window, or unmapped space. Eight low addresses reach an 8-byte RAM. Three addresses inside the I/O window form a general-purpose port: a pin-level register, a direction register and an output-value register. The remaining window addresses and all addresses outside both regions are inert.

The port drives a per-pin output enable and an output value. External tristate buffers use these to drive eight bidirectional pins. The pin levels return through a two-flop synchronizer and can be read at the pin-level address. A write to that same address does not store anything. Instead it inverts each output bit that has a 1 in the written byte, so software can flip a pin without a read-modify-write sequence.

Reads are combinational and valid in the cycle the read strobe is high. Writes take effect on the clock edge that samples the write strobe. The three decode regions are named RGN_RAM, RGN_IO and RGN_NONE. The port selections within the I/O window are named IOS_PIN, IOS_DIR, IOS_OUT and IOS_NONE.

Top module: `dspace_gpio`

## Requirements
- R1: During and after reset, pin_oe and pin_out are 0x00, and every RAM byte, the direction register and the output register read 0x00.
- R2: Addresses 0x00 to 0x07 hold eight independent bytes. A write stores the byte, and later reads of that address return it.
- R3: A write to 0x37 sets the direction register. pin_oe equals the written value after that clock edge, with bit n = 1 meaning pin n is an output. Reads of 0x37 return the value last written.
- R4: A write to 0x38 sets the output register. pin_out equals the written value after that clock edge, and reads of 0x38 return it.
- R5: A read of 0x36 returns pin_in as it was two clock edges earlier. A change on pin_in is not visible after one edge and is visible after two edges.
- R6: A write to 0x36 replaces the output register with its old value XOR the written byte on the same edge. It leaves the direction register unchanged. Writing 0x00 has no effect.
- R7: Addresses 0x08 to 0x1F and 0x60 to 0xFF read 0x00. Writes to them change no RAM byte, no port register and no pin output.
- R8: Addresses in 0x20 to 0x5F other than 0x36, 0x37 and 0x38 read 0x00. Writes to them have no effect.
- R9: While bus_re is low, bus_rdata is 0x00.
- R10: When a read and a write to the same address share a cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Data-space address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_re | input | 1 | Read strobe, enables bus_rdata |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Levels sensed on the eight pins, asynchronous |
| pin_oe | output | 8 | Per-pin output enable (1 = drive) |
| pin_out | output | 8 | Per-pin output value |

## Verification
On every cycle, the embedded assertions check several properties. Each port register and each RAM byte holds its value unless a write targets it. A write to the pin-level address lands as an XOR on the next cycle. The synchronized pin value trails pin_in by exactly two edges. Unmapped or idle reads return zero.

Only the bench scenarios can show the rest. These include the end-to-end address map: which specific addresses reach which register, and that the unused window addresses are inert. They also include the read-before-write ordering when both strobes share a cycle, and the visible pin_oe and pin_out effects after sequences of writes and toggles.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_RAM,
        RGN_IO
    } region_e;

    typedef enum logic [1:0] {
        IOS_NONE,
        IOS_PIN,
        IOS_DIR,
        IOS_OUT
    } io_sel_e;

endpackage

// File: rtl/dspace_decode.sv
module dspace_decode
    import dspace_pkg::*;
#(
    parameter int             AW        = 8,
    parameter int             RAM_DEPTH = 8,
    parameter logic [AW-1:0]  RAM_BASE  = 8'h00,
    parameter logic [AW-1:0]  IO_LO     = 8'h20,
    parameter logic [AW-1:0]  IO_HI     = 8'h5F,
    parameter logic [AW-1:0]  PIN_ADDR  = 8'h36,
    parameter logic [AW-1:0]  DIR_ADDR  = 8'h37,
    parameter logic [AW-1:0]  OUT_ADDR  = 8'h38,
    localparam int            RAM_AW    = $clog2(RAM_DEPTH)
) (
    input  logic [AW-1:0]     addr,
    output region_e           region,
    output io_sel_e           io_sel,
    output logic [RAM_AW-1:0] ram_idx
);

    logic [AW-1:0] ram_off;
    logic          ram_hit;
    logic          io_hit;

    assign ram_off = addr - RAM_BASE;
    assign ram_hit = ram_off < AW'(RAM_DEPTH);
    assign io_hit  = (addr >= IO_LO) && (addr <= IO_HI);
    assign ram_idx = ram_off[RAM_AW-1:0];

    always_comb begin
        region = RGN_NONE;
        if (ram_hit)     region = RGN_RAM;
        else if (io_hit) region = RGN_IO;
    end

    always_comb begin
        io_sel = IOS_NONE;
        if (region == RGN_IO) begin
            if (addr == PIN_ADDR)      io_sel = IOS_PIN;
            else if (addr == DIR_ADDR) io_sel = IOS_DIR;
            else if (addr == OUT_ADDR) io_sel = IOS_OUT;
        end
    end

endmodule

// File: rtl/dspace_ram.sv
module dspace_ram #(
    parameter int  DW     = 8,
    parameter int  DEPTH  = 8,
    localparam int RAM_AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RAM_AW-1:0] idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_hold
        AST_RAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && idx == RAM_AW'(g)) |=> $stable(mem[g])); // R7
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [1:0]   warm;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= 1'b0;
                stage2[g] <= 1'b0;
            end else begin
                stage1[g] <= async_in[g];
                stage2[g] <= stage1[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    assign sync_out = stage2;

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (sync_out == $past(async_in, 2))); // R5

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import dspace_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  io_sel_e      sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (we) begin
            unique case (sel)
                IOS_DIR: dir_q <= wdata;
                IOS_OUT: out_q <= wdata;
                IOS_PIN: out_q <= out_q ^ wdata;
                default: ;
            endcase
        end
    end

    AST_TOGGLE_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == IOS_PIN) |=> (out_q == ($past(out_q) ^ $past(wdata)))); // R6
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == IOS_DIR) |=> $stable(dir_q)); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (sel == IOS_OUT || sel == IOS_PIN)) |=> $stable(out_q)); // R4

endmodule

// File: rtl/dspace_gpio.sv
module dspace_gpio
    import dspace_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter int            RAM_DEPTH = 8,
    parameter logic [AW-1:0] RAM_BASE  = 8'h00,
    parameter logic [AW-1:0] IO_LO     = 8'h20,
    parameter logic [AW-1:0] IO_HI     = 8'h5F,
    parameter logic [AW-1:0] PIN_ADDR  = 8'h36,
    parameter logic [AW-1:0] DIR_ADDR  = 8'h37,
    parameter logic [AW-1:0] OUT_ADDR  = 8'h38
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_oe,
    output logic [DW-1:0] pin_out
);

    localparam int RAM_AW = $clog2(RAM_DEPTH);

    region_e           region;
    io_sel_e           io_sel;
    logic [RAM_AW-1:0] ram_idx;
    logic [DW-1:0]     ram_rd;
    logic [DW-1:0]     pin_sync;
    logic [DW-1:0]     dir_q;
    logic [DW-1:0]     out_q;
    logic [DW-1:0]     rd_val;
    logic              ram_we;
    logic              io_we;

    dspace_decode #(
        .AW(AW), .RAM_DEPTH(RAM_DEPTH), .RAM_BASE(RAM_BASE),
        .IO_LO(IO_LO), .IO_HI(IO_HI),
        .PIN_ADDR(PIN_ADDR), .DIR_ADDR(DIR_ADDR), .OUT_ADDR(OUT_ADDR)
    ) u_decode (
        .addr    (bus_addr),
        .region  (region),
        .io_sel  (io_sel),
        .ram_idx (ram_idx)
    );

    assign ram_we = bus_we && (region == RGN_RAM);
    assign io_we  = bus_we && (region == RGN_IO);

    dspace_ram #(.DW(DW), .DEPTH(RAM_DEPTH)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (bus_wdata),
        .rdata (ram_rd)
    );

    gpio_sync #(.W(DW)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_port #(.W(DW)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (io_we),
        .sel   (io_sel),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    always_comb begin
        rd_val = '0;
        unique case (region)
            RGN_RAM: rd_val = ram_rd;
            RGN_IO: begin
                unique case (io_sel)
                    IOS_PIN: rd_val = pin_sync;
                    IOS_DIR: rd_val = dir_q;
                    IOS_OUT: rd_val = out_q;
                    default: rd_val = '0;
                endcase
            end
            default: rd_val = '0;
        endcase
    end

    assign bus_rdata = bus_re ? rd_val : '0;
    assign pin_oe    = dir_q;
    assign pin_out   = out_q;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && region == RGN_NONE) |-> (bus_rdata == '0)); // R7
    AST_WINDOW_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && region == RGN_IO && io_sel == IOS_NONE) |-> (bus_rdata == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0)); // R9

endmodule

// File: tb/tb_dspace_gpio.sv
module tb_dspace_gpio;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_we;
    logic       bus_re;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    always #10 clk = ~clk;

    dspace_gpio dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    int         n_chk  = 0;
    int         n_fail = 0;
    string      qtag[$];
    logic [7:0] qexp[$];
    string      mtag;
    logic [7:0] mexp;
    logic [7:0] ram_model [8];

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: pops the scoreboard on every read cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n === 1'b1 && bus_re === 1'b1) begin
            if (qexp.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL scoreboard underflow actual=%02h expected=none", bus_rdata);
            end else begin
                mtag = qtag.pop_front();
                mexp = qexp.pop_front();
                check(mtag, bus_rdata, mexp);
            end
        end
    end

    // Driver tasks: entered and left at posedge + 2
    task automatic do_read(logic [7:0] a, logic [7:0] exp, string tag);
        bus_addr = a;
        bus_re   = 1'b1;
        qtag.push_back(tag);
        qexp.push_back(exp);
        @(posedge clk); #2;
        bus_re = 1'b0;
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic do_rw(logic [7:0] a, logic [7:0] d, logic [7:0] exp, string tag);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        bus_re    = 1'b1;
        qtag.push_back(tag);
        qexp.push_back(exp);
        @(posedge clk); #2;
        bus_we = 1'b0;
        bus_re = 1'b0;
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0;
        bus_we = 1'b0; bus_re = 1'b0; pin_in = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        check("R1 pin_oe in reset", pin_oe, 8'h00);
        check("R1 pin_out in reset", pin_out, 8'h00);
        rst_n = 1'b1;
        @(posedge clk); #2;

        // R1: reset contents
        for (int i = 0; i < 8; i++) do_read(8'(i), 8'h00, "R1 ram reset");
        do_read(8'h37, 8'h00, "R1 dir reset");
        do_read(8'h38, 8'h00, "R1 out reset");
        check("R1 pin_oe after reset", pin_oe, 8'h00);

        // R2: RAM bytes, read back in reverse order
        for (int i = 0; i < 8; i++) begin
            ram_model[i] = 8'(i * 17 + 3);
            do_write(8'(i), ram_model[i]);
        end
        for (int i = 7; i >= 0; i--) do_read(8'(i), ram_model[i], "R2 ram readback");

        // R9: idle read strobe gives zero
        bus_addr = 8'h01;
        @(negedge clk);
        check("R9 rdata idle", bus_rdata, 8'h00);
        @(posedge clk); #2;

        // R3: direction register
        do_write(8'h37, 8'hA5);
        check("R3 pin_oe", pin_oe, 8'hA5);
        do_read(8'h37, 8'hA5, "R3 dir readback");

        // R4: output register
        do_write(8'h38, 8'h3C);
        check("R4 pin_out", pin_out, 8'h3C);
        do_read(8'h38, 8'h3C, "R4 out readback");

        // R6: toggle through the pin-level address
        do_write(8'h36, 8'h0F);
        check("R6 toggle 0F", pin_out, 8'h33);
        check("R6 dir unchanged", pin_oe, 8'hA5);
        do_write(8'h36, 8'h00);
        check("R6 toggle 00", pin_out, 8'h33);
        do_write(8'h36, 8'hFF);
        check("R6 toggle FF", pin_out, 8'hCC);
        do_write(8'h36, 8'h04);
        check("R6 toggle bit2", pin_out, 8'hC8);
        do_read(8'h38, 8'hC8, "R6 out readback");

        // R5: two-edge synchronizer latency
        pin_in = 8'h5A;
        @(posedge clk); #2;
        do_read(8'h36, 8'h00, "R5 one edge");
        do_read(8'h36, 8'h5A, "R5 two edges");
        pin_in = 8'hC3;
        @(posedge clk); #2;
        @(posedge clk); #2;
        do_read(8'h36, 8'hC3, "R5 second pattern");

        // R10: read and write in the same cycle
        do_rw(8'h38, 8'h77, 8'hC8, "R10 old out value");
        do_read(8'h38, 8'h77, "R10 new out value");
        do_rw(8'h03, 8'h99, ram_model[3], "R10 old ram value");
        ram_model[3] = 8'h99;
        do_read(8'h03, 8'h99, "R10 new ram value");

        // R7: unmapped addresses
        do_write(8'h08, 8'hEE);
        do_write(8'h1F, 8'hEE);
        do_write(8'h60, 8'hEE);
        do_write(8'hFF, 8'hEE);
        do_read(8'h08, 8'h00, "R7 read 08");
        do_read(8'h1F, 8'h00, "R7 read 1F");
        do_read(8'h60, 8'h00, "R7 read 60");
        do_read(8'hFF, 8'h00, "R7 read FF");
        for (int i = 0; i < 8; i++) do_read(8'(i), ram_model[i], "R7 ram untouched");
        check("R7 pin_oe untouched", pin_oe, 8'hA5);
        check("R7 pin_out untouched", pin_out, 8'h77);

        // R8: unused I/O window addresses
        do_write(8'h20, 8'h11);
        do_write(8'h35, 8'h22);
        do_write(8'h39, 8'h33);
        do_write(8'h5F, 8'h44);
        do_read(8'h20, 8'h00, "R8 read 20");
        do_read(8'h35, 8'h00, "R8 read 35");
        do_read(8'h39, 8'h00, "R8 read 39");
        do_read(8'h5F, 8'h00, "R8 read 5F");
        check("R8 pin_oe untouched", pin_oe, 8'hA5);
        check("R8 pin_out untouched", pin_out, 8'h77);
        do_read(8'h37, 8'hA5, "R8 dir readback");
        do_read(8'h38, 8'h77, "R8 out readback");

        @(posedge clk); #2;
        check("R2 scoreboard drained", 8'(qexp.size()), 8'h00);
        summary();
        $finish;
    end

endmodule